// File: doc/BRIEF.md
# Self-Triggered Hit Timestamper

This block watches a group of sampled amplitude channels and finds hits in them without any trigger input. Every channel compares each new sample with its own threshold. A pulse opens on the first sample strictly above that threshold and closes on the first sample at or below it. The closed pulse becomes a hit record that holds the time of its opening sample and the largest sample it contained. The channel then stays deaf for a programmable number of samples.

Hit records wait in a small buffer inside each channel. A round-robin arbiter moves at most one record per clock into a shared output queue. That queue presents sparse words on a valid/ready interface. The time base is a free-running counter that wraps. On every wrap an epoch word enters the stream, so a downstream stage can rebuild absolute time. When a channel buffer is full, a finished hit is discarded and that channel's loss counter advances.

Top module: `hit_stamper`

## Requirements
- R1: After reset `out_valid` is low and every loss counter in `ovf_o` is zero.
- R2: A hit word carries kind bit 0 (bit 19 with default widths), the channel number in bits [18:16], and in bits [15:8] the time counter value at the first sample strictly above that channel's threshold. The time counter is zero during reset and advances by one on every clock after reset.
- R3: Bits [7:0] of a hit word hold the maximum sample seen from the opening sample up to the sample that closes the pulse.
- R4: A sample equal to the channel's threshold does not open a pulse. Each channel uses its own threshold field `thr_i[8*c +: 8]`.
- R5: The `dead_i` samples that follow the closing sample of a pulse are ignored. The next sample can open a new pulse.
- R6: When several channels hold hits, grants rotate in channel order starting after the channel served last. Every hit is delivered.
- R7: A hit that closes while its channel buffer is full is discarded, and that channel's counter `ovf_o[8*c +: 8]` increments by one. The counters of other channels do not change.
- R8: Each wrap of the time counter from 255 to 0 queues one epoch word: kind bit 1, channel and time fields 0, amplitude field holding the number of earlier epoch words modulo 256. Epoch words take precedence over hits.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` holds steady. A word leaves the queue only on a cycle with both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and readout clock; one time-counter tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_i | input | NCH*AW | Current sample of every channel, channel c at [AW*c +: AW] |
| thr_i | input | NCH*AW | Per-channel threshold, same packing |
| dead_i | input | DW | Number of samples ignored after each pulse |
| out_valid | output | 1 | Output queue holds a word |
| out_ready | input | 1 | Consumer accepts the word this cycle |
| out_data | output | 1+CW+TSW+AW | Kind, channel, time, amplitude |
| ovf_o | output | NCH*OVW | Per-channel loss counters |

## Verification
The bench uses eight channels, 8-bit amplitudes and an 8-bit time counter. With these values the counter wraps every 256 clocks, so several epoch words and their sequence numbers can be checked in a few hundred cycles. The channel buffers hold four entries and the output queue holds eight. Stalling the consumer while one channel fires fourteen short pulses therefore fills both levels and forces losses. A 4-bit dead-time field lets the bench place a pulse inside and just after the deaf window. Firing all eight channels on the same clock exposes the full rotation of the arbiter.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic {KIND_HIT = 1'b0, KIND_EPOCH = 1'b1} word_kind_e;

  function automatic int rr_next(input int cur, input int n);
    return (cur + 1) % n;
  endfunction
endpackage

// File: rtl/hs_fifo.sv
module hs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [PW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
  assign dout  = mem[rp[PW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[PW-1:0]] <= din;
  end
endmodule

// File: rtl/hs_channel.sv
module hs_channel #(
  parameter int AW    = 8,
  parameter int TSW   = 8,
  parameter int DW    = 4,
  parameter int DEPTH = 4,
  parameter int OVW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      samp,
  input  logic [AW-1:0]      thr,
  input  logic [DW-1:0]      dead,
  input  logic [TSW-1:0]     ts,
  input  logic               pop,
  output logic               has_hit,
  output logic [TSW+AW-1:0]  hit_rec,
  output logic               drop,
  output logic [OVW-1:0]     ovf
);
  function automatic logic [AW-1:0] amp_max(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic          in_pulse;
  logic [DW-1:0] dcnt;
  logic [TSW-1:0] ts_lat;
  logic [AW-1:0] peak;
  logic          above, deaf, open_p, close_p, buf_empty, buf_full;

  assign above   = samp > thr;
  assign deaf    = (dcnt != '0);
  assign open_p  = !deaf && !in_pulse && above;
  assign close_p = !deaf && in_pulse && !above;
  assign drop    = close_p && buf_full;
  assign has_hit = !buf_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pulse <= 1'b0;
      dcnt     <= '0;
      ts_lat   <= '0;
      peak     <= '0;
      ovf      <= '0;
    end else begin
      if (deaf) dcnt <= dcnt - 1'b1;
      if (open_p) begin
        in_pulse <= 1'b1;
        ts_lat   <= ts;
        peak     <= samp;
      end else if (in_pulse && above && !deaf) begin
        peak <= amp_max(peak, samp);
      end
      if (close_p) begin
        in_pulse <= 1'b0;
        dcnt     <= dead;
      end
      if (drop) ovf <= ovf + 1'b1;
    end
  end

  hs_fifo #(.W(TSW+AW), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(close_p), .pop(pop),
    .din({ts_lat, peak}), .dout(hit_rec), .empty(buf_empty), .full(buf_full)
  );
endmodule

// File: rtl/hs_rr_arb.sv
module hs_rr_arb #(
  parameter int N  = 8,
  parameter int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  grant,
  output logic [CW-1:0] gidx
);
  logic [CW-1:0] ptr;
  logic          found;
  int            idx;

  always_comb begin
    grant = '0;
    gidx  = '0;
    found = 1'b0;
    idx   = 0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr) + k) % N;
      if (!found && req[idx]) begin
        found      = 1'b1;
        grant[idx] = adv;
        gidx       = CW'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (|grant) ptr <= CW'(hs_pkg::rr_next(int'(gidx), N));
  end
endmodule

// File: rtl/hit_stamper.sv
module hit_stamper #(
  parameter int NCH       = 8,
  parameter int AW        = 8,
  parameter int TSW       = 8,
  parameter int DW        = 4,
  parameter int BUF_DEPTH = 4,
  parameter int OUT_DEPTH = 8,
  parameter int OVW       = 8,
  localparam int CW       = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int HW       = TSW + AW,
  localparam int WW       = 1 + CW + HW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH*AW-1:0] samp_i,
  input  logic [NCH*AW-1:0] thr_i,
  input  logic [DW-1:0]    dead_i,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WW-1:0]    out_data,
  output logic [NCH*OVW-1:0] ovf_o
);
  import hs_pkg::*;

  function automatic logic [WW-1:0] make_hit(input logic [CW-1:0] ch, input logic [HW-1:0] rec);
    return {KIND_HIT, ch, rec};
  endfunction

  function automatic logic [WW-1:0] make_epoch(input logic [AW-1:0] n);
    return {KIND_EPOCH, {CW{1'b0}}, {TSW{1'b0}}, n};
  endfunction

  logic [TSW-1:0] ts;
  logic           wrap, epoch_pend, mk_push, adv, ofull, oempty, opush;
  logic [AW-1:0]  epoch_cnt;
  logic [NCH-1:0] ch_req, grant, drop_w;
  logic [CW-1:0]  gidx;
  logic [HW-1:0]  hit_data [NCH];
  logic [WW-1:0]  odin;

  assign wrap    = &ts;
  assign mk_push = epoch_pend && !ofull;
  assign adv     = !ofull && !epoch_pend;
  assign opush   = mk_push || (|grant);
  assign odin    = mk_push ? make_epoch(epoch_cnt) : make_hit(gidx, hit_data[gidx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts         <= '0;
      epoch_pend <= 1'b0;
      epoch_cnt  <= '0;
    end else begin
      ts         <= ts + 1'b1;
      epoch_pend <= wrap || (epoch_pend && !mk_push);
      if (mk_push) epoch_cnt <= epoch_cnt + 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    hs_channel #(.AW(AW), .TSW(TSW), .DW(DW), .DEPTH(BUF_DEPTH), .OVW(OVW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .samp(samp_i[c*AW +: AW]), .thr(thr_i[c*AW +: AW]), .dead(dead_i), .ts(ts),
      .pop(grant[c]), .has_hit(ch_req[c]), .hit_rec(hit_data[c]),
      .drop(drop_w[c]), .ovf(ovf_o[c*OVW +: OVW])
    );
  end

  hs_rr_arb #(.N(NCH), .CW(CW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(ch_req), .adv(adv), .grant(grant), .gidx(gidx)
  );

  hs_fifo #(.W(WW), .DEPTH(OUT_DEPTH)) u_out (
    .clk(clk), .rst_n(rst_n), .push(opush), .pop(out_ready && !oempty),
    .din(odin), .dout(out_data), .empty(oempty), .full(ofull)
  );

  assign out_valid = !oempty;
endmodule

// File: rtl/hit_stamper_chk.sv
module hit_stamper_chk #(
  parameter int NCH = 8,
  parameter int WW  = 20,
  parameter int OVW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               out_valid,
  input logic               out_ready,
  input logic [WW-1:0]      out_data,
  input logic [NCH-1:0]     grant,
  input logic [NCH-1:0]     ch_req,
  input logic [NCH-1:0]     drop_w,
  input logic [NCH*OVW-1:0] ovf_o,
  input logic               epoch_pend,
  input logic               ofull
);
  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r6_grant_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> ((grant & ch_req) == grant));

  a_r8_epoch_first: assert property (@(posedge clk) disable iff (!rst_n)
    (epoch_pend && !ofull) |-> (grant == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_ovf
    a_r7_drop_counts: assert property (@(posedge clk) disable iff (!rst_n)
      drop_w[c] |=> (ovf_o[c*OVW +: OVW] == OVW'($past(ovf_o[c*OVW +: OVW]) + 1'b1)));
    a_r7_no_spurious_count: assert property (@(posedge clk) disable iff (!rst_n)
      !drop_w[c] |=> $stable(ovf_o[c*OVW +: OVW]));
  end
endmodule

bind hit_stamper hit_stamper_chk #(.NCH(NCH), .WW(WW), .OVW(OVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .grant(grant), .ch_req(ch_req), .drop_w(drop_w),
  .ovf_o(ovf_o), .epoch_pend(epoch_pend), .ofull(ofull)
);

// File: tb/sim_hit_stamper.sv
module sim_hit_stamper;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8, AW = 8, TSW = 8, DW = 4, OVW = 8;
  localparam int WW = 1 + 3 + TSW + AW;

  logic clk = 1'b0, rst_n = 1'b0, out_ready = 1'b1, out_valid;
  logic [NCH*AW-1:0] samp_i, thr_i;
  logic [DW-1:0] dead_i = '0;
  logic [WW-1:0] out_data;
  logic [NCH*OVW-1:0] ovf_o;
  logic [AW-1:0] s [NCH];
  logic [AW-1:0] th [NCH];
  logic [TSW-1:0] tb_ts;
  logic [WW-1:0] q [$];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb for (int i = 0; i < NCH; i++) begin
    samp_i[i*AW +: AW] = s[i];
    thr_i[i*AW +: AW]  = th[i];
  end

  always @(posedge clk) tb_ts <= rst_n ? tb_ts + 8'd1 : 8'd0;
  always @(negedge clk) if (rst_n && out_valid && out_ready) q.push_back(out_data);

  hit_stamper #(.NCH(NCH), .AW(AW), .TSW(TSW), .DW(DW), .BUF_DEPTH(4),
                .OUT_DEPTH(8), .OVW(OVW)) u0 (
    .clk(clk), .rst_n(rst_n), .samp_i(samp_i), .thr_i(thr_i), .dead_i(dead_i),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .ovf_o(ovf_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit w_kind(input logic [WW-1:0] w); return w[WW-1]; endfunction
  function automatic int w_ch(input logic [WW-1:0] w); return int'(w[WW-2 -: 3]); endfunction
  function automatic int w_ts(input logic [WW-1:0] w); return int'(w[AW+TSW-1 -: TSW]); endfunction
  function automatic int w_amp(input logic [WW-1:0] w); return int'(w[AW-1:0]); endfunction

  function automatic int count_hits(input int ch);
    int n = 0;
    foreach (q[i]) if (!w_kind(q[i]) && w_ch(q[i]) == ch) n++;
    return n;
  endfunction

  function automatic logic [WW-1:0] nth_hit(input int ch, input int n);
    int k = 0;
    foreach (q[i]) if (!w_kind(q[i]) && w_ch(q[i]) == ch) begin
      if (k == n) return q[i];
      k++;
    end
    return '0;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(ovf_o == '0, "R1 loss counters after reset", int'(|ovf_o), 0);
  endtask

  task automatic t_single;
    int ets;
    logic [WW-1:0] w;
    q.delete(); th[2] = 8'd50;
    @(negedge clk); s[2] = 8'd60; ets = int'(tb_ts);
    @(negedge clk); s[2] = 8'd90;
    @(negedge clk); s[2] = 8'd70;
    @(negedge clk); s[2] = 8'd40;
    @(negedge clk); s[2] = 8'd0;
    idle(8);
    chk(count_hits(2) == 1, "R2 one hit word ch2", count_hits(2), 1);
    w = nth_hit(2, 0);
    chk(w_ts(w) == ets, "R2 time stamp of first sample", w_ts(w), ets);
    chk(w_amp(w) == 90, "R3 peak amplitude", w_amp(w), 90);
  endtask

  task automatic t_threshold;
    logic [WW-1:0] w;
    q.delete(); th[5] = 8'd100; th[6] = 8'd20;
    @(negedge clk); s[5] = 8'd100; s[6] = 8'd21;
    @(negedge clk); s[6] = 8'd0;
    @(negedge clk); s[5] = 8'd0;
    idle(8);
    chk(count_hits(5) == 0, "R4 equal sample is no hit", count_hits(5), 0);
    chk(count_hits(6) == 1, "R4 low threshold channel hits", count_hits(6), 1);
    w = nth_hit(6, 0);
    chk(w_amp(w) == 21, "R4 ch6 amplitude", w_amp(w), 21);
    @(negedge clk); s[5] = 8'd101;
    @(negedge clk); s[5] = 8'd0;
    idle(8);
    w = nth_hit(5, 0);
    chk(count_hits(5) == 1 && w_amp(w) == 101, "R4 ch5 above threshold", w_amp(w), 101);
  endtask

  task automatic t_dead;
    int ets;
    logic [WW-1:0] w;
    q.delete(); th[1] = 8'd10; dead_i = 4'd3;
    @(negedge clk); s[1] = 8'd50;
    @(negedge clk); s[1] = 8'd0;
    repeat (3) begin @(negedge clk); s[1] = 8'd80; end
    @(negedge clk); s[1] = 8'd77; ets = int'(tb_ts);
    @(negedge clk); s[1] = 8'd0;
    idle(12);
    dead_i = 4'd0;
    chk(count_hits(1) == 2, "R5 hits around dead window", count_hits(1), 2);
    w = nth_hit(1, 1);
    chk(w_amp(w) == 77, "R5 deaf samples ignored", w_amp(w), 77);
    chk(w_ts(w) == ets, "R5 pulse after dead window stamped", w_ts(w), ets);
  endtask

  task automatic t_round_robin;
    int chs [$];
    q.delete();
    for (int i = 0; i < NCH; i++) th[i] = 8'd10;
    @(negedge clk); for (int i = 0; i < NCH; i++) s[i] = 8'd30;
    @(negedge clk); for (int i = 0; i < NCH; i++) s[i] = 8'd0;
    idle(20);
    for (int i = 0; i < NCH; i++) th[i] = 8'd200;
    foreach (q[i]) if (!w_kind(q[i])) chs.push_back(w_ch(q[i]));
    chk(chs.size() == NCH, "R6 all hits delivered", chs.size(), NCH);
    for (int i = 1; i < chs.size(); i++)
      chk(chs[i] == (chs[i-1] + 1) % NCH, "R6 rotation order", chs[i], (chs[i-1] + 1) % NCH);
  endtask

  task automatic t_overflow;
    int lost, got;
    th[3] = 8'd10;
    @(negedge clk); out_ready = 1'b0;
    repeat (14) begin
      @(negedge clk); s[3] = 8'd40;
      @(negedge clk); s[3] = 8'd0;
    end
    idle(4);
    lost = int'(ovf_o[3*OVW +: OVW]);
    chk(lost >= 1, "R7 losses counted", lost, 1);
    chk(ovf_o[4*OVW +: OVW] == '0, "R7 other channel untouched", int'(ovf_o[4*OVW +: OVW]), 0);
    q.delete(); out_ready = 1'b1;
    idle(40);
    got = count_hits(3);
    chk(got + lost == 14, "R7 delivered plus lost", got + lost, 14);
    th[3] = 8'd200;
  endtask

  task automatic t_epoch;
    int ep [$];
    q.delete();
    idle(600);
    foreach (q[i]) if (w_kind(q[i])) begin
      ep.push_back(w_amp(q[i]));
      chk(w_ch(q[i]) == 0 && w_ts(q[i]) == 0, "R8 epoch word fields", w_ts(q[i]), 0);
    end
    chk(ep.size() >= 2, "R8 epoch words per wrap", ep.size(), 2);
    for (int i = 1; i < ep.size(); i++)
      chk(ep[i] == (ep[i-1] + 1) % 256, "R8 epoch sequence", ep[i], (ep[i-1] + 1) % 256);
  endtask

  task automatic t_handshake;
    logic [WW-1:0] w0;
    int n = 0;
    th[0] = 8'd10;
    @(negedge clk); out_ready = 1'b0;
    @(negedge clk); s[0] = 8'd55;
    @(negedge clk); s[0] = 8'd0;
    idle(4);
    chk(out_valid == 1'b1, "R9 word waiting", int'(out_valid), 1);
    w0 = out_data;
    idle(5);
    chk(out_data == w0, "R9 data held during stall", int'(out_data), int'(w0));
    q.delete(); out_ready = 1'b1;
    idle(6);
    foreach (q[i]) if (q[i] == w0) n++;
    chk(n == 1, "R9 word delivered once", n, 1);
    chk(w_amp(w0) == 55 || w_kind(w0), "R9 held word content", w_amp(w0), 55);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin s[i] = '0; th[i] = 8'd200; end
    idle(3);
    t_reset;
    rst_n = 1'b1;
    idle(2);
    t_single;
    t_threshold;
    t_dead;
    t_round_robin;
    t_overflow;
    t_epoch;
    t_handshake;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule